// File: doc/BRIEF.md
# Receive Descriptor Ring Scatter Writer

This block places one received frame into memory through a ring of receive descriptors. A frame arrives as a length, a 32-bit CRC value and a byte stream that the block pulls one byte at a time. The block stores the frame bytes followed by the four CRC bytes. Before it writes anything, it walks the ring from the current descriptor and checks that enough empty descriptors exist to hold the whole stored size, counting each one as one maximum-size buffer. If the space is there, the block fills buffers in ring order and updates each descriptor. If it is not, the frame is refused and memory is left untouched.

Each descriptor is 8 bytes, big-endian, and 8-byte aligned. Bytes 0..1 hold a 16-bit flag word, bytes 2..3 hold the written length, and bytes 4..7 hold the buffer pointer. After each frame, and on a receive demand while the controller is enabled, the block reads the empty flag of the current descriptor and copies it into an rx-active output. Frames that arrive while rx-active is low are dropped. The memory port works one byte per access and returns read data one cycle after the request is registered, so it suits a block RAM.

Top module: `rxr_scatter_top`

## Requirements
- R1: While reset is held, rx_active, mem_en, frm_done and both event outputs are 0.
- R2: The stored size is frm_len + 4. Stored positions below size-4 carry frame bytes in stream order. The last four positions carry frm_crc, most significant byte first.
- R3: If frm_len + 4 exceeds 2032, the stored size becomes 2032. The last descriptor's flag low byte (address +1) then gets bit 0 (truncated) and bit 5 (length violation) set.
- R4: If the stored size is greater than frame_limit, bit 5 of the last descriptor's flag low byte is set.
- R5: The ring is walked from the current descriptor. An empty descriptor with remaining size at most the maximum buffer size accepts the frame; otherwise one maximum buffer size is subtracted and the walk moves on. If a descriptor is reached whose empty flag (bit 7 of byte +0) is clear, frm_drop is pulsed with frm_done and no memory write occurs.
- R6: The maximum buffer size is max_buf with bits 3..0 cleared. Each buffer receives min(remaining, max buffer size) bytes from its pointer upward. That count is written big-endian to bytes +2..+3.
- R7: Every used descriptor has its empty flag cleared. The final one also gets the last flag (bit 3 of byte +0) and pulses ev_rxf. Each earlier one pulses ev_rxb.
- R8: A descriptor with the wrap flag (bit 5 of byte +0) is followed by the ring base. Otherwise the next descriptor is 8 bytes higher.
- R9: rx_active takes the empty flag of the current descriptor after each stored frame, and on rx_demand while ctl_en is high and rx_active is low. It is 0 one cycle after ctl_en is low.
- R10: A frame started while rx_active is low is dropped (frm_drop with frm_done) with no memory write.
- R11: The CRC bytes follow the frame bytes across a buffer boundary, so a buffer may end with the leading CRC bytes and the next one holds the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller enable |
| rx_demand | input | 1 | Receive demand pulse (re-arm request) |
| ring_load | input | 1 | Loads ring_base as ring base and current descriptor |
| ring_base | input | ADDR_W | Descriptor ring base address (low 3 bits ignored) |
| max_buf | input | BUF_W | Maximum buffer size, bits 3..0 ignored |
| frame_limit | input | 16 | Frame size limit for the length-violation flag |
| frm_start | input | 1 | Starts a frame |
| frm_len | input | LEN_W | Frame length in bytes, without CRC |
| frm_crc | input | 32 | CRC value appended after the frame |
| frm_data | input | 8 | Current frame byte (first-word-fall-through) |
| frm_take | output | 1 | Current frame byte consumed this cycle |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| ev_rxb | output | 1 | Buffer-done event pulse |
| ev_rxf | output | 1 | Frame-done event pulse |
| frm_done | output | 1 | Frame handling finished |
| frm_drop | output | 1 | Frame dropped or refused (with frm_done) |
| rx_active | output | 1 | Receive armed |

## Verification
A wrong walk or wrap pointer appears at the ports within the frame it affects. It shows up as a write to an address the ring model does not expect, or as a refusal where space existed. Either is caught on that clock by comparing every memory write against a precomputed image. A wrong size, CRC byte order or flag merge leaves a single wrong byte, which the full-image comparison at frm_done exposes. A wrong rx_active is visible on the cycle of frm_done, or a few cycles after a demand. A stale ring position shows up at the latest in the placement of the next frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_WALK, S_DRD, S_BUF, S_DWR, S_ARM
  } rxr_state_t;

  localparam int DESC_BYTES = 8;
  localparam int HI_EMPTY   = 7;
  localparam int HI_WRAP    = 5;
  localparam logic [7:0] HI_LAST_M  = 8'h08;
  localparam logic [7:0] HI_EMPTY_M = 8'h80;
  localparam int LO_TRUNC   = 0;
  localparam int LO_LONG    = 5;
  localparam int CRC_BYTES  = 4;
endpackage

// File: rtl/rxr_sizer.sv
module rxr_sizer #(
  parameter int LEN_W     = 12,
  parameter int MAX_FRAME = 2032,
  localparam int SIZE_W   = LEN_W + 1
) (
  input  logic [LEN_W-1:0]  len,
  input  logic [15:0]       limit,
  output logic [SIZE_W-1:0] size,
  output logic              trunc,
  output logic              over
);
  logic [SIZE_W-1:0] full;

  always_comb begin
    full  = SIZE_W'(len) + SIZE_W'(rxr_pkg::CRC_BYTES);
    trunc = full > SIZE_W'(MAX_FRAME);
    size  = trunc ? SIZE_W'(MAX_FRAME) : full;
    over  = trunc | (32'(size) > 32'(limit));
  end
endmodule

// File: rtl/rxr_byte_sel.sv
module rxr_byte_sel #(
  parameter int SIZE_W = 13
) (
  input  logic [SIZE_W-1:0] pos,
  input  logic [SIZE_W-1:0] data_cnt,
  input  logic [31:0]       crc,
  input  logic [7:0]        frame_byte,
  output logic [7:0]        out_byte,
  output logic              is_data
);
  logic [1:0] cidx;

  always_comb begin
    is_data = pos < data_cnt;
    cidx    = 2'(pos - data_cnt);
    unique case (cidx)
      2'd0: out_byte = crc[31:24];
      2'd1: out_byte = crc[23:16];
      2'd2: out_byte = crc[15:8];
      default: out_byte = crc[7:0];
    endcase
    if (is_data) out_byte = frame_byte;
  end
endmodule

// File: rtl/rxr_scatter_top.sv
module rxr_scatter_top #(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 12,
  parameter int BUF_W     = 11,
  parameter int MAX_FRAME = 2032
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_en,
  input  logic              rx_demand,
  input  logic              ring_load,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [BUF_W-1:0]  max_buf,
  input  logic [15:0]       frame_limit,
  input  logic              frm_start,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [31:0]       frm_crc,
  input  logic [7:0]        frm_data,
  output logic              frm_take,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              ev_rxb,
  output logic              ev_rxf,
  output logic              frm_done,
  output logic              frm_drop,
  output logic              rx_active
);
  import rxr_pkg::*;

  localparam int SIZE_W = LEN_W + 1;
  localparam logic [BUF_W-1:0] BUF_MASK = {{(BUF_W-4){1'b1}}, 4'b0000};

  rxr_state_t        st;
  logic [1:0]        ph;
  logic [2:0]        step;
  logic [ADDR_W-1:0] base_q, cptr, wptr, dptr, dofs;
  logic [SIZE_W-1:0] want, rem, pos, size_q, data_q, blen, bcnt, mbr_q, mbr_now;
  logic [31:0]       crc_q;
  logic [7:0]        fhi, flo, stat_q, sel_byte;
  logic              arm_frame, walk_ok, sel_data, last_buf;
  logic [SIZE_W-1:0] sz;
  logic              sz_tr, sz_lg;

  rxr_sizer #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) i_sizer (
    .len(frm_len), .limit(frame_limit), .size(sz), .trunc(sz_tr), .over(sz_lg)
  );

  rxr_byte_sel #(.SIZE_W(SIZE_W)) i_sel (
    .pos(pos), .data_cnt(data_q), .crc(crc_q), .frame_byte(frm_data),
    .out_byte(sel_byte), .is_data(sel_data)
  );

  assign mbr_now  = {{(SIZE_W-BUF_W){1'b0}}, max_buf & BUF_MASK};
  assign frm_take = (st == S_BUF) && sel_data;
  assign last_buf = (rem == '0);
  assign dofs     = ADDR_W'(step) + ((step >= 3'd2) ? ADDR_W'(2) : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ph <= '0; step <= '0;
      base_q <= '0; cptr <= '0; wptr <= '0; dptr <= '0;
      want <= '0; rem <= '0; pos <= '0; size_q <= '0; data_q <= '0;
      blen <= '0; bcnt <= '0; mbr_q <= '0; crc_q <= '0;
      fhi <= '0; flo <= '0; stat_q <= '0;
      arm_frame <= 1'b0; walk_ok <= 1'b0;
      mem_en <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      ev_rxb <= 1'b0; ev_rxf <= 1'b0; frm_done <= 1'b0; frm_drop <= 1'b0;
      rx_active <= 1'b0;
    end else begin
      mem_en <= 1'b0; mem_we <= 1'b0;
      ev_rxb <= 1'b0; ev_rxf <= 1'b0; frm_done <= 1'b0; frm_drop <= 1'b0;
      unique case (st)
        S_IDLE: begin
          ph <= '0;
          if (frm_start) begin
            if (rx_active && (mbr_now != '0)) begin
              size_q <= sz;
              data_q <= sz - SIZE_W'(CRC_BYTES);
              stat_q <= 8'(sz_lg) << LO_LONG | 8'(sz_tr) << LO_TRUNC;
              crc_q  <= frm_crc;
              mbr_q  <= mbr_now;
              want   <= sz;
              wptr   <= cptr;
              st     <= S_WALK;
            end else begin
              frm_done <= 1'b1; frm_drop <= 1'b1;
            end
          end else if (ring_load) begin
            base_q <= {ring_base[ADDR_W-1:3], 3'b000};
            cptr   <= {ring_base[ADDR_W-1:3], 3'b000};
          end else if (rx_demand && ctl_en && !rx_active) begin
            arm_frame <= 1'b0;
            st <= S_ARM;
          end
        end
        S_WALK: begin
          if (ph == 2'd0) begin
            mem_en <= 1'b1; mem_addr <= wptr; ph <= 2'd1;
          end else if (ph == 2'd1) begin
            ph <= 2'd2;
          end else begin
            ph <= 2'd0;
            if (!mem_rdata[HI_EMPTY]) begin
              frm_done <= 1'b1; frm_drop <= 1'b1; st <= S_IDLE;
            end else if (want <= mbr_q) begin
              walk_ok <= 1'b1; rem <= size_q; pos <= '0; step <= '0;
              st <= S_DRD;
            end else begin
              want <= want - mbr_q;
              wptr <= mem_rdata[HI_WRAP] ? base_q : wptr + ADDR_W'(DESC_BYTES);
            end
          end
        end
        S_DRD: begin
          if (ph == 2'd0) begin
            mem_en <= 1'b1; mem_addr <= cptr + dofs; ph <= 2'd1;
          end else if (ph == 2'd1) begin
            ph <= 2'd2;
          end else begin
            ph <= 2'd0;
            if (step == 3'd0)      fhi  <= mem_rdata;
            else if (step == 3'd1) flo  <= mem_rdata;
            else                   dptr <= {dptr[ADDR_W-9:0], mem_rdata};
            if (step == 3'd5) begin
              blen <= (rem <= mbr_q) ? rem : mbr_q;
              bcnt <= '0;
              st   <= S_BUF;
            end else begin
              step <= step + 3'd1;
            end
          end
        end
        S_BUF: begin
          mem_en <= 1'b1; mem_we <= 1'b1;
          mem_addr  <= dptr + ADDR_W'(bcnt);
          mem_wdata <= sel_byte;
          pos <= pos + 1'b1;
          if (bcnt == blen - 1'b1) begin
            rem  <= rem - blen;
            step <= '0;
            st   <= S_DWR;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        S_DWR: begin
          mem_en <= 1'b1; mem_we <= 1'b1;
          mem_addr <= cptr + ADDR_W'(step);
          unique case (step)
            3'd0:    mem_wdata <= (fhi & ~HI_EMPTY_M) | (last_buf ? HI_LAST_M : 8'h00);
            3'd1:    mem_wdata <= flo | (last_buf ? stat_q : 8'h00);
            3'd2:    mem_wdata <= 8'(blen[SIZE_W-1:8]);
            default: mem_wdata <= blen[7:0];
          endcase
          if (step == 3'd3) begin
            cptr <= fhi[HI_WRAP] ? base_q : cptr + ADDR_W'(DESC_BYTES);
            step <= '0; ph <= '0;
            if (last_buf) begin
              ev_rxf <= 1'b1; arm_frame <= 1'b1; st <= S_ARM;
            end else begin
              ev_rxb <= 1'b1; st <= S_DRD;
            end
          end else begin
            step <= step + 3'd1;
          end
        end
        S_ARM: begin
          if (ph == 2'd0) begin
            mem_en <= 1'b1; mem_addr <= cptr; ph <= 2'd1;
          end else if (ph == 2'd1) begin
            ph <= 2'd2;
          end else begin
            ph <= 2'd0;
            rx_active <= mem_rdata[HI_EMPTY];
            walk_ok   <= 1'b0;
            frm_done  <= arm_frame;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (!ctl_en) rx_active <= 1'b0;
    end
  end

  // R7: a buffer event and a frame event never coincide
  p_one_event_r7: assert property (@(posedge clk) disable iff (rst)
    !(ev_rxb && ev_rxf));

  // R9: disabling the controller drops rx-active on the next cycle
  p_disable_clears_r9: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |=> !rx_active);

  // R2: when the frame event fires, every stored byte has been written
  p_all_bytes_r2: assert property (@(posedge clk) disable iff (rst)
    ev_rxf |-> (pos == size_q));

  // R5: no memory write unless the space walk succeeded
  p_write_after_walk_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |-> walk_ok);

  // R6: a buffer never receives more than the maximum buffer size
  p_buf_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_BUF) |-> (bcnt < mbr_q));

  // R10: a dropped frame produces no frame event
  p_drop_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    frm_drop |-> (frm_done && !ev_rxf && !ev_rxb));
endmodule

// File: tb/test_rxr_scatter_top.sv
module test_rxr_scatter_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;
  localparam int LW = 12;
  localparam int MEMSZ = 1 << AW;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst, ctl_en, rx_demand, ring_load, frm_start;
  logic [AW-1:0] ring_base;
  logic [10:0]   max_buf;
  logic [15:0]   frame_limit;
  logic [LW-1:0] frm_len;
  logic [31:0]   frm_crc;
  logic [7:0]    frm_data;
  logic          frm_take, mem_en, mem_we, ev_rxb, ev_rxf, frm_done, frm_drop, rx_active;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;

  logic [7:0] mem     [0:MEMSZ-1];
  logic [7:0] exp_mem [0:MEMSZ-1];
  logic [7:0] fbuf    [0:4095];
  logic [11:0] fidx;
  logic tb_we;
  logic [AW-1:0] tb_addr;
  logic [7:0] tb_data;

  int n_chk = 0, n_fail = 0;
  int got_rxb, got_rxf, exp_rxb, exp_rxf;
  int m_cptr, m_base;
  bit m_active, exp_drop, exp_wr;

  rxr_scatter_top #(.ADDR_W(AW), .LEN_W(LW)) i_rxr_scatter_top (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .rx_demand(rx_demand),
    .ring_load(ring_load), .ring_base(ring_base), .max_buf(max_buf),
    .frame_limit(frame_limit), .frm_start(frm_start), .frm_len(frm_len),
    .frm_crc(frm_crc), .frm_data(frm_data), .frm_take(frm_take),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ev_rxb(ev_rxb),
    .ev_rxf(ev_rxf), .frm_done(frm_done), .frm_drop(frm_drop),
    .rx_active(rx_active)
  );

  assign frm_data = fbuf[fidx];

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr];
    if (frm_start) fidx <= '0;
    else if (frm_take) fidx <= fidx + 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // every clock: each write must match the model image; count events
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_en && mem_we) begin
        if (!exp_wr) chk(1'b0, "R5/R10 write on dropped frame", int'(mem_addr), -1);
        else chk(exp_mem[mem_addr] === mem_wdata, "R2 write data", int'(mem_wdata),
                 int'(exp_mem[mem_addr]));
      end
      if (ev_rxb) got_rxb++;
      if (ev_rxf) got_rxf++;
    end
  end

  task automatic poke(input int a, input int d);
    tb_we = 1'b1; tb_addr = AW'(a); tb_data = 8'(d);
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic setup_ring(input int n);
    for (int i = 0; i < n; i++) begin
      int p;
      p = 16'h1000 + i * 16'h800;
      poke(8*i,   8'h80 | ((i == n-1) ? 8'h20 : 8'h00));
      poke(8*i+1, 0); poke(8*i+2, 0); poke(8*i+3, 0);
      poke(8*i+4, 0); poke(8*i+5, 0);
      poke(8*i+6, p >> 8); poke(8*i+7, p & 255);
    end
    ring_base = '0; ring_load = 1'b1;
    @(negedge clk);
    ring_load = 1'b0;
    m_cptr = 0; m_base = 0;
  endtask

  task automatic demand();
    rx_demand = 1'b1;
    @(negedge clk);
    rx_demand = 1'b0;
    repeat (6) @(negedge clk);
    if (ctl_en && !m_active) m_active = mem[m_cptr][7];
  endtask

  function automatic int dptr_of(input int a);
    return ((int'(exp_mem[a+6]) << 8) | int'(exp_mem[a+7])) & (MEMSZ-1);
  endfunction

  task automatic run_model(input int len, input logic [31:0] crc, input int limit, input int mbr);
    int s, want, a, rem, p, bl, ptr;
    bit tr, lg, ok;
    for (int i = 0; i < MEMSZ; i++) exp_mem[i] = mem[i];
    s = len + 4; tr = 0; lg = 0;
    if (s > 2032) begin s = 2032; tr = 1; lg = 1; end
    if (s > limit) lg = 1;
    exp_rxb = 0; exp_rxf = 0; exp_drop = 0;
    if (!m_active || mbr == 0) exp_drop = 1;
    else begin
      want = s; a = m_cptr; ok = 0;
      while (1) begin
        if (!exp_mem[a][7]) break;
        if (want <= mbr) begin ok = 1; break; end
        want -= mbr;
        a = exp_mem[a][5] ? m_base : a + 8;
      end
      if (!ok) exp_drop = 1;
    end
    exp_wr = !exp_drop;
    if (exp_drop) return;
    rem = s; p = 0; a = m_cptr;
    while (rem > 0) begin
      bl = (rem <= mbr) ? rem : mbr;
      ptr = dptr_of(a);
      for (int k = 0; k < bl; k++) begin
        if (p < s - 4) exp_mem[(ptr + k) & (MEMSZ-1)] = fbuf[p];
        else exp_mem[(ptr + k) & (MEMSZ-1)] = crc[31 - 8*(p - (s - 4)) -: 8];
        p++;
      end
      rem -= bl;
      exp_mem[a] = exp_mem[a] & 8'h7F;
      if (rem == 0) begin
        exp_mem[a]   = exp_mem[a] | 8'h08;
        exp_mem[a+1] = exp_mem[a+1] | (tr ? 8'h01 : 8'h00) | (lg ? 8'h20 : 8'h00);
        exp_rxf++;
      end else exp_rxb++;
      exp_mem[a+2] = 8'(bl >> 8);
      exp_mem[a+3] = 8'(bl & 255);
      a = exp_mem[a][5] ? m_base : a + 8;
    end
    m_cptr = a;
    m_active = exp_mem[a][7];
  endtask

  task automatic send(input int len, input logic [31:0] crc, input int limit,
                      input int maxb, input int seed, input string tag);
    int t, bad;
    for (int i = 0; i < 4096; i++) fbuf[i] = 8'((i * 7 + seed) & 255);
    max_buf = 11'(maxb); frame_limit = 16'(limit);
    run_model(len, crc, limit, maxb & 16'h7F0);
    got_rxb = 0; got_rxf = 0;
    frm_len = LW'(len); frm_crc = crc; frm_start = 1'b1;
    @(negedge clk);
    frm_start = 1'b0;
    t = 0;
    while (!frm_done && t < 20000) begin @(negedge clk); t++; end
    chk(frm_done, {tag, " frame completion"}, int'(frm_done), 1);
    chk(frm_drop == exp_drop, {tag, " drop flag"}, int'(frm_drop), int'(exp_drop));
    chk(rx_active == m_active, {tag, " R9 rx_active after frame"}, int'(rx_active), int'(m_active));
    @(negedge clk);
    exp_wr = 0;
    chk(got_rxb == exp_rxb, {tag, " R7 buffer events"}, got_rxb, exp_rxb);
    chk(got_rxf == exp_rxf, {tag, " R7 frame events"}, got_rxf, exp_rxf);
    bad = 0;
    for (int i = 0; i < MEMSZ; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, {tag, " memory image"}, bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; ctl_en = 1'b0; rx_demand = 1'b0; ring_load = 1'b0; frm_start = 1'b0;
    ring_base = '0; max_buf = 11'h040; frame_limit = 16'd1518; frm_len = '0;
    frm_crc = '0; tb_we = 1'b0; tb_addr = '0; tb_data = '0;
    exp_wr = 0; m_active = 0; m_cptr = 0; m_base = 0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    chk(!rx_active && !mem_en && !frm_done && !ev_rxb && !ev_rxf, "R1 reset state",
        int'({rx_active, mem_en, frm_done, ev_rxb, ev_rxf}), 0);
    rst = 1'b0;
    @(negedge clk);
    ctl_en = 1'b1;
    setup_ring(4);
    // R10: not armed yet, frame dropped
    send(40, 32'hA1B2C3D4, 1518, 11'h040, 1, "R10 unarmed");
    demand();
    chk(rx_active == 1'b1, "R9 demand arms", int'(rx_active), 1);
    // R2 R6: exact fit in one buffer of 64
    send(60, 32'h11223344, 1518, 11'h040, 2, "R2 R6 single buffer");
    // R11: CRC split over two buffers (64 + 2)
    send(62, 32'hCAFEF00D, 1518, 11'h040, 3, "R11 crc split");
    // R5: needs two buffers, wrap leads to a used descriptor
    send(100, 32'h0BADBEEF, 1518, 11'h040, 4, "R5 refused");
    // R4 R8: limit violation, wrap to base, re-arm sees used descriptor
    send(30, 32'h55AA55AA, 20, 11'h040, 5, "R4 R8 limit and wrap");
    chk(rx_active == 1'b0, "R9 re-arm low", int'(rx_active), 0);
    send(20, 32'h01020304, 1518, 11'h040, 6, "R10 inactive drop");
    setup_ring(4);
    demand();
    // R3: truncation with the largest buffer size
    send(2040, 32'hDEADBEEF, 1518, 11'h7FF, 7, "R3 truncation");
    // R6: low bits of max_buf ignored, 104 bytes over 64+40
    send(100, 32'h89ABCDEF, 1518, 11'h04F, 8, "R6 mask and R7 multi");
    ctl_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(rx_active == 1'b0, "R9 disable clears", int'(rx_active), 0);
    m_active = 0;
    demand();
    chk(rx_active == 1'b0, "R9 demand ignored while disabled", int'(rx_active), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule